// File: doc/BRIEF.md
# DMA Global Control and Fault Flag Unit

This block is the global control and fault-status register of a small DMA controller. It keeps one master enable bit and two sticky fault flags. One flag records an addressing fault reported by the transfer engine. The other records a non-maskable interrupt. The block combines these with a per-channel enable and drives a registered transfer-permit signal. When an NMI arrives while a transfer unit is running, the block raises a stop request so that the engine ends at the unit boundary.

Software uses a plain register port to reach the block. Each port cycle carries an address, a read strobe, a write strobe and write data, and read data is returned in the same cycle. Software cannot set either flag. A flag clears only when 0 is written to it after a read that returned it as 1. A read that coincides with the flag being raised returns 0 for that flag, but it still counts as a 1-read for the clear that follows. The control pins carry no handshake. The engine signals `unit_start` and `unit_done` as single-cycle pulses.

Top module: `dma_gsr_ctrl`

## Requirements
- R1: After reset the master enable, both flags, `xfer_permit` and `stop_req` are 0, and a register read returns 0.
- R2: At address `CSR_ADDR`, bit 0 is the master enable (read/write), bit 1 is the fault flag and bit 2 is the NMI flag. All other bits read as 0, and a read at any other address returns 0.
- R3: A pulse on `addr_err_evt` sets the fault flag, and a pulse on `nmi_evt` sets the NMI flag. This happens whether or not a transfer is running.
- R4: Writing 1 to a flag bit never sets that flag.
- R5: Writing 0 to a set flag leaves it at 1 unless a read that showed it as 1 came before the write.
- R6: Writing 0 to a flag clears it when a read that showed it as 1 came before the write, with no write in between. Any write uses up that armed state.
- R7: A read in the same cycle as a flag's set event returns 0 for that flag. A following write of 0 still clears the flag.
- R8: A set event in the same cycle as a clearing write leaves the flag at 1.
- R9: `xfer_permit` is registered. It is 1 one cycle after `chan_en` and the master enable are 1 with both flags clear, and it is 0 one cycle after the master enable is 0.
- R10: While the fault flag is 1, `xfer_permit` is 0 from the following cycle on.
- R11: If the NMI flag becomes set while a unit is in progress, `stop_req` is 1 and `xfer_permit` stays 1 until `unit_done`. One cycle after the unit ends, `xfer_permit` is 0.
- R12: While the NMI flag is 1 and no unit is in progress, `xfer_permit` is 0 from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register address |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, same cycle as `reg_re` |
| addr_err_evt | input | 1 | Engine reports an addressing fault |
| nmi_evt | input | 1 | Non-maskable interrupt event |
| chan_en | input | 1 | Channel enable |
| unit_start | input | 1 | Engine begins a transfer unit |
| unit_done | input | 1 | Engine finishes the current transfer unit |
| xfer_permit | output | 1 | Registered permission to transfer |
| stop_req | output | 1 | Finish the current unit and then stop |

## Verification
The hardest case to reach from the ports is a read that lands in the same cycle as a flag's set event. The read shows 0 for that flag, but the clear must still be armed. The stimulus table drives the event pulse and the read strobe in one row, writes 0 in the next row, and then reads again to confirm the flag is gone. A second hard case is an NMI that arrives while a unit is open. The directed test opens a unit, injects the NMI, and checks that `stop_req` is high and `xfer_permit` stays high until the `unit_done` pulse. It then checks that `xfer_permit` falls one cycle after the unit ends.

// File: rtl/dma_gsr_pkg.sv
package dma_gsr_pkg;
  localparam int ME_BIT   = 0;
  localparam int AE_BIT   = 1;
  localparam int NMI_BIT  = 2;
  localparam int N_FLAGS  = 2;
  // flag index inside the flag array: 0 = fault, 1 = NMI
  localparam int FLG_AE   = 0;
  localparam int FLG_NMI  = 1;
endpackage

// File: rtl/dma_sticky_flag.sv
module dma_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic rd_hit,
  input  logic wr_hit,
  input  logic wr_bit,
  output logic flag,
  output logic armed
);
  logic flag_n, armed_n;

  always_comb begin
    flag_n = flag;
    if (wr_hit && !wr_bit && armed) flag_n = 1'b0;
    if (set_evt) flag_n = 1'b1;           // set beats clear
    armed_n = armed;
    if (rd_hit && (flag || set_evt)) armed_n = 1'b1;
    if (wr_hit) armed_n = 1'b0;           // any write consumes the arm
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      flag  <= flag_n;
      armed <= armed_n;
    end
  end
endmodule

// File: rtl/dma_unit_track.sv
module dma_unit_track (
  input  logic clk,
  input  logic rst_n,
  input  logic unit_start,
  input  logic unit_done,
  input  logic permit,
  input  logic nmi_flag,
  output logic in_unit,
  output logic stop_req
);
  assign stop_req = nmi_flag && in_unit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_unit <= 1'b0;
    else        in_unit <= (in_unit && !unit_done) ||
                           (unit_start && permit && !stop_req);
  end
endmodule

// File: rtl/dma_gsr_ctrl.sv
module dma_gsr_ctrl #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int CSR_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              addr_err_evt,
  input  logic              nmi_evt,
  input  logic              chan_en,
  input  logic              unit_start,
  input  logic              unit_done,
  output logic              xfer_permit,
  output logic              stop_req
);
  import dma_gsr_pkg::*;

  localparam logic [ADDR_W-1:0] SEL = ADDR_W'(CSR_ADDR);

  logic sel, rd_hit, wr_hit;
  logic me_q, in_unit;
  logic [N_FLAGS-1:0] flag_q, arm_q, evt, wbit;

  assign sel    = (reg_addr == SEL);
  assign rd_hit = sel && reg_re;
  assign wr_hit = sel && reg_we;
  assign evt    = {nmi_evt, addr_err_evt};
  assign wbit   = {reg_wdata[NMI_BIT], reg_wdata[AE_BIT]};

  generate
    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
      dma_sticky_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_evt(evt[g]),
        .rd_hit (rd_hit),
        .wr_hit (wr_hit),
        .wr_bit (wbit[g]),
        .flag   (flag_q[g]),
        .armed  (arm_q[g])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      me_q <= 1'b0;
    else if (wr_hit) me_q <= reg_wdata[ME_BIT];
  end

  always_comb begin
    reg_rdata = '0;
    if (rd_hit) begin
      reg_rdata[ME_BIT]  = me_q;
      reg_rdata[AE_BIT]  = flag_q[FLG_AE];
      reg_rdata[NMI_BIT] = flag_q[FLG_NMI];
    end
  end

  dma_unit_track u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .unit_start(unit_start),
    .unit_done (unit_done),
    .permit    (xfer_permit),
    .nmi_flag  (flag_q[FLG_NMI]),
    .in_unit   (in_unit),
    .stop_req  (stop_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) xfer_permit <= 1'b0;
    else        xfer_permit <= chan_en && me_q && !flag_q[FLG_AE] &&
                               !(flag_q[FLG_NMI] && !in_unit);
  end
endmodule

// File: rtl/dma_gsr_chk.sv
module dma_gsr_chk (
  input logic clk,
  input logic rst_n,
  input logic me,
  input logic ae,
  input logic nmif,
  input logic ae_arm,
  input logic in_unit,
  input logic wr_hit,
  input logic ae_evt,
  input logic chan_en,
  input logic xfer_permit,
  input logic stop_req
);
  // R10: fault flag blocks the permit on the next cycle
  a_r10_fault_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ae |=> !xfer_permit);
  // R12: idle NMI blocks the permit
  a_r12_idle_nmi_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (nmif && !in_unit) |=> !xfer_permit);
  // R11: an open unit keeps its permit while the stop is requested
  a_r11_unit_finishes: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && chan_en && me && !ae) |=> xfer_permit);
  // R9: master enable off means no permit
  a_r9_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !me |=> !xfer_permit);
  // R8: a set event always leaves the flag high
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ae_evt |=> ae);
  // R5: an unarmed write cannot clear the flag
  a_r5_unarmed_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (ae && wr_hit && !ae_arm) |=> ae);
  // R4: no way to raise the flag except the event
  a_r4_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!ae && !ae_evt) |=> !ae);
endmodule

bind dma_gsr_ctrl dma_gsr_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .me         (me_q),
  .ae         (flag_q[0]),
  .nmif       (flag_q[1]),
  .ae_arm     (arm_q[0]),
  .in_unit    (in_unit),
  .wr_hit     (wr_hit),
  .ae_evt     (addr_err_evt),
  .chan_en    (chan_en),
  .xfer_permit(xfer_permit),
  .stop_req   (stop_req)
);

// File: tb/dma_gsr_ctrl_tb_top.sv
module dma_gsr_ctrl_tb_top;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int NV = 22;
  // row = {re, we, wd[2:0], ae_evt, nmi_evt, exp_rd[2:0]}
  localparam logic [9:0] VEC [NV] = '{
    10'b1_0_000_0_0_000, // 0  R1 reset reads 0
    10'b0_1_001_0_0_000, // 1  R2 set master enable
    10'b1_0_000_0_0_001, // 2  R2 read back
    10'b1_0_000_1_0_001, // 3  R7 read with set: fault reads 0
    10'b0_1_001_0_0_000, // 4  R7 write 0 clears
    10'b1_0_000_0_0_001, // 5  R7 cleared
    10'b0_0_000_0_1_000, // 6  R3 nmi idle
    10'b0_1_001_0_0_000, // 7  R5 write 0 unarmed
    10'b1_0_000_0_0_101, // 8  R5 still set (arms)
    10'b0_1_101_0_0_000, // 9  R6 write consumes arm
    10'b0_1_001_0_0_000, // 10 R6 write 0 now unarmed
    10'b1_0_000_0_0_101, // 11 R6 still set (arms)
    10'b0_1_001_0_0_000, // 12 R6 armed clear
    10'b1_0_000_0_0_001, // 13 R6 cleared
    10'b0_1_111_0_0_000, // 14 R4 write ones
    10'b1_0_000_0_0_001, // 15 R4 no flag set
    10'b0_0_000_1_0_000, // 16 R3 fault event
    10'b1_0_000_0_0_011, // 17 R3 fault visible (arms)
    10'b0_1_001_1_0_000, // 18 R8 clear and set same cycle
    10'b1_0_000_0_0_011, // 19 R8 stays set (arms)
    10'b0_1_001_0_0_000, // 20 R8 clear
    10'b1_0_000_0_0_001  // 21 R8 cleared
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic reg_we = 0, reg_re = 0, addr_err_evt = 0, nmi_evt = 0;
  logic chan_en = 0, unit_start = 0, unit_done = 0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic xfer_permit, stop_req;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  dma_gsr_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CSR_ADDR(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_re(reg_re), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .addr_err_evt(addr_err_evt), .nmi_evt(nmi_evt), .chan_en(chan_en),
    .unit_start(unit_start), .unit_done(unit_done),
    .xfer_permit(xfer_permit), .stop_req(stop_req));

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    reg_we = 0; reg_re = 0; addr_err_evt = 0; nmi_evt = 0;
    unit_start = 0; unit_done = 0; reg_wdata = '0; reg_addr = '0;
  endtask

  task automatic cyc(); @(negedge clk); idle(); endtask

  task automatic rd_chk(string req, logic [2:0] exp);
    reg_re = 1; #5; chk(req, reg_rdata, {29'd0, exp}); cyc();
  endtask

  task automatic wr(logic [2:0] d);
    reg_we = 1; reg_wdata = {29'd0, d}; cyc();
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    chk("R1 permit", {31'd0, xfer_permit}, 0);
    chk("R1 stop", {31'd0, stop_req}, 0);
    rst_n = 1;
    cyc();
    for (int i = 0; i < NV; i++) begin
      reg_re = VEC[i][9]; reg_we = VEC[i][8];
      reg_wdata = {29'd0, VEC[i][7:5]};
      addr_err_evt = VEC[i][4]; nmi_evt = VEC[i][3];
      #5;
      if (VEC[i][9]) chk($sformatf("table row %0d", i), reg_rdata, {29'd0, VEC[i][2:0]});
      cyc();
    end
    // R2 other address and upper bits
    reg_addr = 4'd5; reg_re = 1; #5;
    chk("R2 other address", reg_rdata, 0); cyc();
    // R9 permit rises one cycle later
    chan_en = 1; cyc();
    chk("R9 permit high", {31'd0, xfer_permit}, 1);
    // R11 nmi during unit
    unit_start = 1; cyc();
    nmi_evt = 1; cyc();
    chk("R11 stop_req", {31'd0, stop_req}, 1);
    chk("R11 permit kept", {31'd0, xfer_permit}, 1);
    cyc();
    chk("R11 permit still", {31'd0, xfer_permit}, 1);
    unit_done = 1; cyc();
    chk("R11 stop drops", {31'd0, stop_req}, 0);
    cyc();
    chk("R11 permit low", {31'd0, xfer_permit}, 0);
    rd_chk("R11 nmi flag", 3'b101);
    wr(3'b001); cyc();
    chk("R9 permit back", {31'd0, xfer_permit}, 1);
    // R10 fault blocks
    addr_err_evt = 1; cyc(); cyc();
    chk("R10 fault blocks", {31'd0, xfer_permit}, 0);
    rd_chk("R10 flag", 3'b011);
    wr(3'b001); cyc();
    chk("R10 recovers", {31'd0, xfer_permit}, 1);
    // R12 idle nmi blocks
    nmi_evt = 1; cyc(); cyc();
    chk("R12 idle nmi blocks", {31'd0, xfer_permit}, 0);
    chk("R12 no stop", {31'd0, stop_req}, 0);
    rd_chk("R12 flag", 3'b101);
    wr(3'b001); cyc();
    // R9 master enable off
    wr(3'b000); cyc();
    chk("R9 master off", {31'd0, xfer_permit}, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule